// File: doc/BRIEF.md
# Two-Wire Bit-Level to Byte Transaction Bridge

This block listens to the clock and data levels of a two-wire serial bus driven by a bit-banging controller. It turns the bus activity into byte-level requests on a simple backend port. It detects the start and stop conditions, assembles incoming bits into bytes, and forwards the first byte after a start as a 7-bit target address with a direction flag. Later bytes of a write go out as data. The backend decides per byte whether the bridge acknowledges or refuses.

On a read, the bridge fetches one byte from the backend at the first bit of each byte and presents it most significant bit first. It then watches the controller's acknowledge to decide whether to continue or stop. The bridge drives the data line in open-drain fashion: its drive output is 1 to release and 0 to pull low. A bus-level output gives the wired-AND of that drive with the controller's data level. Both bus inputs pass through a two-stage synchronizer. Edges are found by comparing each synchronized sample with the previous one. When both lines change in the same sample, the data-line change is evaluated first.

Top module: `i2c_byte_bridge`

## Requirements
- R1: After reset the bridge is idle with no accepted address, `sda_drive_o` and `sda_bus_o` are 1, and no backend strobe is active.
- R2: A 1-to-0 change of data while clock is high is a start: it discards any current address and starts assembling a new byte, so a repeated start produces a fresh `be_start_o` for the next address byte without an `be_end_o`.
- R3: On the ninth clock rise after a start, the bridge raises `be_start_o` for one cycle with `be_addr_o` = byte bits 7:1 and `be_rnw_o` = byte bit 0 (1 = read); if `be_ack_i` is 1 it drives `sda_drive_o` to 0 until the next clock fall.
- R4: If the address is refused (`be_ack_i` = 0), the bridge releases data and goes idle: further bytes produce no strobes and no acknowledge until the next start.
- R5: In a write, each further byte raises `be_write_o` with `be_wdata_o` on its ninth clock rise. An accepted byte is acknowledged. A refused byte is not acknowledged, raises `be_end_o` in the same cycle, and sends the bridge idle.
- R6: A 0-to-1 change of data while clock is high is a stop: it raises `be_end_o` only when an address had been accepted, and returns the bridge to idle.
- R7: Data changes while clock is low are neither start nor stop and do not alter the byte being received.
- R8: After an accepted read address, the bridge raises `be_read_o` once at the first clock rise of each read byte. It then presents `be_rdata_i` on `sda_drive_o` most significant bit first, one bit per clock rise.
- R9: After eight read bits, a low data level at the next clock rise continues with another read byte. A high level raises `be_nack_o`, after which the bridge keeps data released and issues no read strobes until a stop or start.
- R10: Every clock fall releases the bridge's drive (`sda_drive_o` = 1).
- R11: `sda_bus_o` equals `sda_drive_o` ANDed with the synchronized controller data level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level from the controller |
| sda_i | input | 1 | Bus data level from the controller |
| sda_drive_o | output | 1 | Bridge open-drain drive, 0 pulls low, 1 releases |
| sda_bus_o | output | 1 | Resolved data level (drive AND controller data) |
| be_start_o | output | 1 | One-cycle request to begin a transfer |
| be_addr_o | output | 7 | Target address for the begin request |
| be_rnw_o | output | 1 | Direction for the begin request, 1 = read |
| be_write_o | output | 1 | One-cycle request to write a byte |
| be_wdata_o | output | 8 | Byte for the write request |
| be_read_o | output | 1 | One-cycle request to fetch a read byte |
| be_rdata_i | input | 8 | Byte returned in the same cycle as the read request |
| be_nack_o | output | 1 | One-cycle notice that the controller refused a read byte |
| be_end_o | output | 1 | One-cycle request to end the transfer |
| be_ack_i | input | 1 | Backend accept (1) or refuse (0), valid with begin and write |

## Verification
The hardest state to reach is the parked state after a controller refusal in a read. The stimulus gets there by first passing a read address the backend accepts, then clocking out a full byte that is acknowledged and a second byte that is refused. It then keeps toggling the clock to show that no read request follows. The silent idle state after a refused address or refused write byte is reached the same way, by aiming a byte at a value the bench's backend model refuses and then sending more bytes. Glitches on data while clock is low are placed inside a byte to show they leave its value intact.

// File: rtl/i2c_bridge_pkg.sv
package i2c_bridge_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned BIT_CNT_W = $clog2(BYTE_W);
    localparam int unsigned TGT_W = BYTE_W - 1;

    typedef enum logic [2:0] {
        BR_IDLE  = 3'd0,
        BR_WBITS = 3'd1,
        BR_WACK  = 3'd2,
        BR_RBITS = 3'd3,
        BR_RACK  = 3'd4,
        BR_PARK  = 3'd5
    } br_state_e;

    typedef struct packed {
        br_state_e             state;
        logic [BIT_CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0]     shreg;
        logic                  have_addr;
        logic                  drive;
    } br_regs_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic prev_o
);

    localparam int unsigned CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d;
    logic [CHAIN_W-1:0] chain_q;

    generate
        if (CHAIN_W > 1) begin : g_chain
            always_comb begin
                chain_d = {chain_q[CHAIN_W-2:0], line_i};
            end
        end else begin : g_single
            always_comb begin
                chain_d = line_i;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign level_o = chain_q[CHAIN_W-2];
    assign prev_o  = chain_q[CHAIN_W-1];

endmodule

// File: rtl/i2c_bridge_fsm.sv
module i2c_bridge_fsm
    import i2c_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              scl_prv,
    input  logic              sda_lvl,
    input  logic              sda_prv,
    output logic              drive_o,
    output logic              be_start_o,
    output logic [TGT_W-1:0]  be_addr_o,
    output logic              be_rnw_o,
    output logic              be_write_o,
    output logic [BYTE_W-1:0] be_wdata_o,
    output logic              be_read_o,
    input  logic [BYTE_W-1:0] be_rdata_i,
    output logic              be_nack_o,
    output logic              be_end_o,
    input  logic              be_ack_i
);

    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    br_regs_t r_d;
    br_regs_t r_q;

    logic              sda_ev;
    logic              scl_ev;
    logic              start_d;
    logic              write_d;
    logic              read_d;
    logic              nack_d;
    logic              end_d;
    logic [BYTE_W-1:0] rd_byte;

    assign sda_ev = sda_lvl ^ sda_prv;
    assign scl_ev = scl_lvl ^ scl_prv;

    always_comb begin
        r_d     = r_q;
        start_d = 1'b0;
        write_d = 1'b0;
        read_d  = 1'b0;
        nack_d  = 1'b0;
        end_d   = 1'b0;
        rd_byte = r_q.shreg;

        // data-line conditions are judged first, against the old clock level
        if (sda_ev && scl_prv) begin
            if (!sda_lvl) begin
                r_d.state     = BR_WBITS;
                r_d.cnt       = '0;
                r_d.have_addr = 1'b0;
            end else begin
                end_d         = r_d.have_addr;
                r_d.have_addr = 1'b0;
                r_d.state     = BR_IDLE;
            end
            r_d.drive = 1'b1;
        end

        if (scl_ev) begin
            if (!scl_lvl) begin
                r_d.drive = 1'b1;
            end else begin
                case (r_d.state)
                    BR_WBITS: begin
                        r_d.shreg = {r_d.shreg[BYTE_W-2:0], sda_lvl};
                        r_d.drive = 1'b1;
                        if (r_d.cnt == LAST_BIT) begin
                            r_d.state = BR_WACK;
                        end
                        r_d.cnt = r_d.cnt + 1'b1;
                    end
                    BR_WACK: begin
                        if (!r_d.have_addr) begin
                            start_d = 1'b1;
                        end else begin
                            write_d = 1'b1;
                        end
                        if (!be_ack_i) begin
                            end_d         = r_d.have_addr;
                            r_d.have_addr = 1'b0;
                            r_d.state     = BR_IDLE;
                            r_d.drive     = 1'b1;
                        end else begin
                            if (!r_d.have_addr) begin
                                r_d.state = r_d.shreg[0] ? BR_RBITS : BR_WBITS;
                            end else begin
                                r_d.state = BR_WBITS;
                            end
                            r_d.have_addr = 1'b1;
                            r_d.cnt       = '0;
                            r_d.drive     = 1'b0;
                        end
                    end
                    BR_RBITS: begin
                        if (r_d.cnt == '0) begin
                            read_d  = 1'b1;
                            rd_byte = be_rdata_i;
                        end else begin
                            rd_byte = r_d.shreg;
                        end
                        r_d.drive = rd_byte[BYTE_W-1];
                        r_d.shreg = {rd_byte[BYTE_W-2:0], 1'b0};
                        if (r_d.cnt == LAST_BIT) begin
                            r_d.state = BR_RACK;
                        end
                        r_d.cnt = r_d.cnt + 1'b1;
                    end
                    BR_RACK: begin
                        r_d.drive = 1'b1;
                        r_d.cnt   = '0;
                        if (sda_lvl) begin
                            nack_d    = 1'b1;
                            r_d.state = BR_PARK;
                        end else begin
                            r_d.state = BR_RBITS;
                        end
                    end
                    default: begin
                        r_d.drive = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= BR_IDLE;
            r_q.cnt       <= '0;
            r_q.shreg     <= '0;
            r_q.have_addr <= 1'b0;
            r_q.drive     <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign drive_o    = r_q.drive;
    assign be_start_o = start_d;
    assign be_write_o = write_d;
    assign be_read_o  = read_d;
    assign be_nack_o  = nack_d;
    assign be_end_o   = end_d;
    assign be_addr_o  = r_q.shreg[BYTE_W-1:1];
    assign be_rnw_o   = r_q.shreg[0];
    assign be_wdata_o = r_q.shreg;

    AST_FALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_ev && !scl_lvl) |=> r_q.drive); // R10
    AST_LOW_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.drive) |-> $past(scl_ev && scl_lvl)); // R3
    AST_REFUSED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (be_start_o && !be_ack_i) |=> (r_q.state == BR_IDLE && r_q.drive)); // R4
    AST_PARK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == BR_PARK) |-> (r_q.drive && !be_read_o)); // R9
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({be_start_o, be_write_o, be_read_o, be_nack_o})); // R5

endmodule

// File: rtl/i2c_byte_bridge.sv
module i2c_byte_bridge
    import i2c_bridge_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_drive_o,
    output logic              sda_bus_o,
    output logic              be_start_o,
    output logic [TGT_W-1:0]  be_addr_o,
    output logic              be_rnw_o,
    output logic              be_write_o,
    output logic [BYTE_W-1:0] be_wdata_o,
    output logic              be_read_o,
    input  logic [BYTE_W-1:0] be_rdata_i,
    output logic              be_nack_o,
    output logic              be_end_o,
    input  logic              be_ack_i
);

    logic scl_lvl, scl_prv, sda_lvl, sda_prv;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (scl_i),
        .level_o (scl_lvl),
        .prev_o  (scl_prv)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (sda_i),
        .level_o (sda_lvl),
        .prev_o  (sda_prv)
    );

    i2c_bridge_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_lvl    (scl_lvl),
        .scl_prv    (scl_prv),
        .sda_lvl    (sda_lvl),
        .sda_prv    (sda_prv),
        .drive_o    (sda_drive_o),
        .be_start_o (be_start_o),
        .be_addr_o  (be_addr_o),
        .be_rnw_o   (be_rnw_o),
        .be_write_o (be_write_o),
        .be_wdata_o (be_wdata_o),
        .be_read_o  (be_read_o),
        .be_rdata_i (be_rdata_i),
        .be_nack_o  (be_nack_o),
        .be_end_o   (be_end_o),
        .be_ack_i   (be_ack_i)
    );

    assign sda_bus_o = sda_drive_o & sda_lvl;

    AST_BUS_PULLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!sda_drive_o) |-> !sda_bus_o); // R11

endmodule

// File: tb/i2c_byte_bridge_test.sv
module i2c_byte_bridge_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       drv, bus;
    logic       st, wr, rd, nk, en, rnw;
    logic [6:0] addr;
    logic [7:0] wdata, rdata;
    logic       ack;

    int n_start = 0, n_write = 0, n_read = 0, n_nack = 0, n_end = 0;
    logic [6:0] last_addr = '0;
    logic       last_rnw = 1'b0;
    logic [7:0] last_wdata = '0;
    int tests = 0, fails = 0;
    bit done = 0;

    localparam logic [6:0] GOOD_ADDR = 7'h2A;

    always #10 clk = ~clk;

    i2c_byte_bridge uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .sda_drive_o(drv), .sda_bus_o(bus),
        .be_start_o(st), .be_addr_o(addr), .be_rnw_o(rnw),
        .be_write_o(wr), .be_wdata_o(wdata), .be_read_o(rd),
        .be_rdata_i(rdata), .be_nack_o(nk), .be_end_o(en), .be_ack_i(ack)
    );

    // backend model: accepts one address, refuses data 8'hFF
    always_comb begin
        ack   = st ? (addr == GOOD_ADDR) : (wdata != 8'hFF);
        rdata = 8'hA5 ^ 8'(n_read);
    end

    always @(posedge clk) begin
        if (st) begin n_start++; last_addr = addr; last_rnw = rnw; end
        if (wr) begin n_write++; last_wdata = wdata; end
        if (rd) n_read++;
        if (nk) n_nack++;
        if (en) n_end++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pins(input logic c, input logic d);
        @(negedge clk);
        scl = c;
        sda = d;
        repeat (6) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_start();
        pins(1'b0, sda);
        pins(1'b0, 1'b1);
        pins(1'b1, 1'b1);
        pins(1'b1, 1'b0);
    endtask

    task automatic do_stop();
        pins(1'b0, sda);
        pins(1'b0, 1'b0);
        pins(1'b1, 1'b0);
        pins(1'b1, 1'b1);
    endtask

    // sends a byte, returns 1 when the bridge pulled data low on the ninth rise
    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            pins(1'b0, sda);
            if (glitch) begin
                pins(1'b0, ~b[i]);
                pins(1'b0, b[i]);
                pins(1'b0, ~b[i]);
            end
            pins(1'b0, b[i]);
            pins(1'b1, b[i]);
        end
        pins(1'b0, sda);
        pins(1'b0, 1'b1);
        pins(1'b1, 1'b1);
        acked = !drv;
        if (acked) check(bus == 1'b0, "R11", bus, 0);
        pins(1'b0, 1'b1);
        check(drv == 1'b1, "R10", drv, 1);
    endtask

    task automatic recv_byte(input bit refuse, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            pins(1'b0, 1'b1);
            pins(1'b1, 1'b1);
            b[i] = drv;
        end
        pins(1'b0, 1'b1);
        pins(1'b0, refuse);
        pins(1'b1, refuse);
        pins(1'b0, refuse);
    endtask

    task automatic t_reset();
        check(drv == 1'b1 && bus == 1'b1, "R1", {drv, bus}, 2'b11);
        check(n_start + n_write + n_read + n_nack + n_end == 0, "R1",
              n_start + n_write + n_read + n_nack + n_end, 0);
    endtask

    task automatic t_write();
        bit a;
        int e0 = n_end;
        do_start();
        send_byte({GOOD_ADDR, 1'b0}, 0, a);
        check(a, "R3", a, 1);
        check(n_start == 1 && last_addr == GOOD_ADDR && last_rnw == 1'b0, "R3",
              last_addr, GOOD_ADDR);
        pins(1'b0, 1'b0);
        check(bus == 1'b0 && drv == 1'b1, "R11", {drv, bus}, 2'b10);
        send_byte(8'h3C, 0, a);
        check(a && n_write == 1 && last_wdata == 8'h3C, "R5", last_wdata, 8'h3C);
        send_byte(8'h96, 1, a);
        check(a && n_write == 2 && last_wdata == 8'h96, "R7", last_wdata, 8'h96);
        do_stop();
        check(n_end == e0 + 1, "R6", n_end, e0 + 1);
    endtask

    task automatic t_bad_addr();
        bit a;
        int s0 = n_start, w0 = n_write, e0 = n_end;
        do_start();
        send_byte({7'h55, 1'b0}, 0, a);
        check(!a && n_start == s0 + 1, "R4", a, 0);
        send_byte(8'h11, 0, a);
        check(!a && n_write == w0 && n_start == s0 + 1, "R4", n_write, w0);
        do_stop();
        check(n_end == e0, "R6", n_end, e0);
    endtask

    task automatic t_write_refused();
        bit a;
        int e0 = n_end, w0;
        do_start();
        send_byte({GOOD_ADDR, 1'b0}, 0, a);
        w0 = n_write;
        send_byte(8'hFF, 0, a);
        check(!a && n_write == w0 + 1 && n_end == e0 + 1, "R5", n_end, e0 + 1);
        send_byte(8'h22, 0, a);
        check(!a && n_write == w0 + 1, "R5", n_write, w0 + 1);
        do_stop();
        check(n_end == e0 + 1, "R6", n_end, e0 + 1);
    endtask

    task automatic t_read();
        bit a;
        logic [7:0] got, exp;
        int r0, e0 = n_end;
        do_start();
        send_byte({GOOD_ADDR, 1'b1}, 0, a);
        check(a && last_rnw == 1'b1, "R3", last_rnw, 1);
        r0 = n_read;
        exp = 8'hA5 ^ 8'(r0);
        recv_byte(0, got);
        check(got == exp && n_read == r0 + 1, "R8", got, exp);
        exp = 8'hA5 ^ 8'(r0 + 1);
        recv_byte(1, got);
        check(got == exp && n_read == r0 + 2, "R9", got, exp);
        check(n_nack == 1, "R9", n_nack, 1);
        for (int i = 0; i < 4; i++) begin
            pins(1'b0, 1'b1);
            pins(1'b1, 1'b1);
            check(drv == 1'b1, "R9", drv, 1);
        end
        check(n_read == r0 + 2, "R9", n_read, r0 + 2);
        do_stop();
        check(n_end == e0 + 1, "R6", n_end, e0 + 1);
    endtask

    task automatic t_restart();
        bit a;
        int s0 = n_start, e0 = n_end;
        do_start();
        send_byte({GOOD_ADDR, 1'b0}, 0, a);
        send_byte(8'h5A, 0, a);
        do_start();
        check(n_end == e0, "R2", n_end, e0);
        send_byte({GOOD_ADDR, 1'b1}, 0, a);
        check(a && n_start == s0 + 2 && last_rnw == 1'b1, "R2", n_start, s0 + 2);
        do_stop();
        check(n_end == e0 + 1, "R6", n_end, e0 + 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_write();
        t_bad_addr();
        t_write_refused();
        t_read();
        t_restart();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule